// File: doc/BRIEF.md
# Power gating sequence controller

This block drives the power-switch enable and the isolation enable of one switchable power domain. A one-cycle power-down request pulse takes the domain from fully on to fully off in two timed steps: isolation is raised first, then the switch is opened. A one-cycle power-up request pulse reverses this: the switch is closed first, then isolation is released. Each of the four steps has its own 6-bit delay, counted in cycles of the block's clock. The delays live in two timing registers on a small synchronous register port.

A power-enable bit in the control register can refuse a power-down. When it is 0, a power-down request leaves the domain powered and only clears the status flag. The status flag records whether the most recent power-down request really removed power. The enable bit is sampled once, at the moment a request is accepted. A busy output shows when a sequence is in flight.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, sw_on=1, iso_on=0 and seq_busy=0, and all four registers read 0.
- R2: Registers are word addressed by reg_addr[3:2]: 0x0 control (bit 0 = power enable), 0x4 power-up timing (bits 5:0 = switch delay, bits 13:8 = isolation-release delay), 0x8 power-down timing (bits 5:0 = isolation delay, bits 13:8 = switch-off delay), 0xC status (bit 0). All other bits read 0. A write to 0xC clears the status bit and cannot set it.
- R3: A power-down request sampled at clock edge t, while the domain is on and the enable is 1, raises iso_on at edge t+ISO+1.
- R4: sw_on falls ISO2SW+1 edges after iso_on rose, and the domain is then off (sw_on=0, iso_on=1).
- R5: A power-up request sampled at edge t while the domain is off raises sw_on at edge t+SW+1.
- R6: iso_on falls SW2ISO+1 edges after sw_on rose, and the domain is then on (sw_on=1, iso_on=0).
- R7: A power-down request with the enable at 0 leaves sw_on, iso_on and seq_busy unchanged and clears the status bit.
- R8: The status bit becomes 1 in the cycle sw_on falls. It stays 1 through the following power-up until a vetoed power-down request or a status write.
- R9: A power-down request is ignored unless the domain is fully on, and a power-up request is ignored unless it is fully off. This includes requests arriving mid-sequence, which leave the sequence timing unchanged.
- R10: The enable bit is sampled only when a power-down request is accepted. Clearing it during the sequence does not stop power-off.
- R11: seq_busy is 1 from the edge that accepts a request until the edge that completes the sequence, and 0 otherwise.
- R12: sw_on is never 0 while iso_on is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all delays are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid during a read access in the same cycle |
| down_req | input | 1 | Power-down request pulse |
| up_req | input | 1 | Power-up request pulse |
| sw_on | output | 1 | Power-switch enable, 1 = domain powered |
| iso_on | output | 1 | Isolation enable, 1 = domain outputs clamped |
| seq_busy | output | 1 | A power sequence is in progress |

## Verification
The two-stage delay chains are swept over every pairing of the values 0, 1, 2, 7 and 63, in both directions. The first-stage delay alone sets when the first edge lands, and the sum sets when the sequence ends, so a swapped field or an off-by-one in either stage shows up as a distinct count. Alternate runs inject both request kinds in the middle of a sequence, which tells ignored requests apart from restarts. Separate runs with the enable held at 0, and with it cleared mid-sequence, tell the veto apart from the sample-once rule.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [2:0] {
      ST_ON,
      ST_DN_ISO,
      ST_DN_SW,
      ST_OFF,
      ST_UP_SW,
      ST_UP_ISO
   } pseq_state_e;

   // word index decoded from address bits [3:2]
   localparam logic [1:0] WD_CTRL = 2'd0;
   localparam logic [1:0] WD_UPT  = 2'd1;
   localparam logic [1:0] WD_DNT  = 2'd2;
   localparam logic [1:0] WD_STAT = 2'd3;

   // bit position of the second delay field in a timing register
   localparam int unsigned FLD2_LSB = 8;

endpackage

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
   import pwr_seq_pkg::*;
#(
   parameter int unsigned DLY_W  = 6,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              status_set,
   input  logic              status_clr,
   output logic              pwr_en,
   output logic [DLY_W-1:0]  up_d1,
   output logic [DLY_W-1:0]  up_d2,
   output logic [DLY_W-1:0]  dn_d1,
   output logic [DLY_W-1:0]  dn_d2,
   output logic              status
);

   localparam int unsigned NFLD = 2;

   logic [1:0]       word;
   logic             hit;
   logic             wr_ctrl, wr_upt, wr_dnt, wr_stat;
   logic [DLY_W-1:0] up_q [NFLD];
   logic [DLY_W-1:0] dn_q [NFLD];
   logic             en_q, stat_q;
   logic             unused_bits;

   assign word    = addr[3:2];
   assign hit     = sel && ((addr >> 4) == '0);
   assign wr_ctrl = hit && wr && (word == WD_CTRL);
   assign wr_upt  = hit && wr && (word == WD_UPT);
   assign wr_dnt  = hit && wr && (word == WD_DNT);
   assign wr_stat = hit && wr && (word == WD_STAT);
   assign unused_bits = ^{wdata, addr[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (wr_ctrl) begin
         en_q <= wdata[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NFLD; i++) begin
            up_q[i] <= '0;
            dn_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < NFLD; i++) begin
            if (wr_upt) up_q[i] <= wdata[i*FLD2_LSB +: DLY_W];
            if (wr_dnt) dn_q[i] <= wdata[i*FLD2_LSB +: DLY_W];
         end
      end
   end

   // a completed power-off takes precedence over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= 1'b0;
      end else if (status_set) begin
         stat_q <= 1'b1;
      end else if (status_clr || wr_stat) begin
         stat_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (hit && !wr) begin
         case (word)
            WD_CTRL: rdata[0] = en_q;
            WD_UPT: begin
               rdata[DLY_W-1:0]           = up_q[0];
               rdata[FLD2_LSB +: DLY_W]   = up_q[1];
            end
            WD_DNT: begin
               rdata[DLY_W-1:0]           = dn_q[0];
               rdata[FLD2_LSB +: DLY_W]   = dn_q[1];
            end
            default: rdata[0] = stat_q;
         endcase
      end
   end

   assign pwr_en = en_q;
   assign up_d1  = up_q[0];
   assign up_d2  = up_q[1];
   assign dn_d1  = dn_q[0];
   assign dn_d2  = dn_q[1];
   assign status = stat_q;

endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
   parameter int unsigned DLY_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] load_val,
   output logic             expired
);

   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
   import pwr_seq_pkg::*;
#(
   parameter int unsigned DLY_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             down_req,
   input  logic             up_req,
   input  logic             pwr_en,
   input  logic [DLY_W-1:0] up_d1,
   input  logic [DLY_W-1:0] up_d2,
   input  logic [DLY_W-1:0] dn_d1,
   input  logic [DLY_W-1:0] dn_d2,
   input  logic             expired,
   output logic             load,
   output logic [DLY_W-1:0] load_val,
   output logic             status_set,
   output logic             status_clr,
   output logic             sw_on,
   output logic             iso_on,
   output logic             busy
);

   pseq_state_e st_q, st_nxt;
   logic        sw_q, iso_q;
   logic        sw_nxt, iso_nxt;

   always_comb begin
      st_nxt     = st_q;
      load       = 1'b0;
      load_val   = '0;
      status_set = 1'b0;
      status_clr = 1'b0;
      case (st_q)
         ST_ON: begin
            if (down_req) begin
               if (pwr_en) begin
                  st_nxt   = ST_DN_ISO;
                  load     = 1'b1;
                  load_val = dn_d1;
               end else begin
                  status_clr = 1'b1;
               end
            end
         end
         ST_DN_ISO: begin
            if (expired) begin
               st_nxt   = ST_DN_SW;
               load     = 1'b1;
               load_val = dn_d2;
            end
         end
         ST_DN_SW: begin
            if (expired) begin
               st_nxt     = ST_OFF;
               status_set = 1'b1;
            end
         end
         ST_OFF: begin
            if (up_req) begin
               st_nxt   = ST_UP_SW;
               load     = 1'b1;
               load_val = up_d1;
            end
         end
         ST_UP_SW: begin
            if (expired) begin
               st_nxt   = ST_UP_ISO;
               load     = 1'b1;
               load_val = up_d2;
            end
         end
         ST_UP_ISO: begin
            if (expired) st_nxt = ST_ON;
         end
         default: st_nxt = ST_ON;
      endcase
   end

   // outputs follow the next state so each edge lands on its transition
   always_comb begin
      iso_nxt = (st_nxt == ST_DN_SW) || (st_nxt == ST_OFF) ||
                (st_nxt == ST_UP_SW) || (st_nxt == ST_UP_ISO);
      sw_nxt  = !((st_nxt == ST_OFF) || (st_nxt == ST_UP_SW));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_ON;
         sw_q  <= 1'b1;
         iso_q <= 1'b0;
      end else begin
         st_q  <= st_nxt;
         sw_q  <= sw_nxt;
         iso_q <= iso_nxt;
      end
   end

   assign sw_on  = sw_q;
   assign iso_on = iso_q;
   assign busy   = (st_q != ST_ON) && (st_q != ST_OFF);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
   import pwr_seq_pkg::*;
#(
   parameter int unsigned DLY_W  = 6,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              down_req,
   input  logic              up_req,
   output logic              sw_on,
   output logic              iso_on,
   output logic              seq_busy
);

   localparam int unsigned MIN_DATA_W = FLD2_LSB + DLY_W;

   if (DLY_W < 1 || DLY_W > FLD2_LSB) begin : g_bad_dly
      $error("pwr_seq_ctrl: DLY_W must lie in 1..%0d", FLD2_LSB);
   end
   if (DATA_W < MIN_DATA_W) begin : g_bad_data
      $error("pwr_seq_ctrl: DATA_W must be at least %0d", MIN_DATA_W);
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("pwr_seq_ctrl: ADDR_W must be at least 4");
   end

   logic             pwr_en_w, status_w;
   logic             st_set, st_clr;
   logic             t_load, t_expired;
   logic [DLY_W-1:0] t_val;
   logic [DLY_W-1:0] up_d1, up_d2, dn_d1, dn_d2;

   pwr_seq_regs #(
      .DLY_W (DLY_W),
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (reg_sel),
      .wr        (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .status_set(st_set),
      .status_clr(st_clr),
      .pwr_en    (pwr_en_w),
      .up_d1     (up_d1),
      .up_d2     (up_d2),
      .dn_d1     (dn_d1),
      .dn_d2     (dn_d2),
      .status    (status_w)
   );

   pwr_seq_timer #(.DLY_W(DLY_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (t_load),
      .load_val(t_val),
      .expired (t_expired)
   );

   pwr_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .down_req  (down_req),
      .up_req    (up_req),
      .pwr_en    (pwr_en_w),
      .up_d1     (up_d1),
      .up_d2     (up_d2),
      .dn_d1     (dn_d1),
      .dn_d2     (dn_d2),
      .expired   (t_expired),
      .load      (t_load),
      .load_val  (t_val),
      .status_set(st_set),
      .status_clr(st_clr),
      .sw_on     (sw_on),
      .iso_on    (iso_on),
      .busy      (seq_busy)
   );

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic down_req,
   input logic up_req,
   input logic sw_on,
   input logic iso_on,
   input logic seq_busy,
   input logic pwr_en,
   input logic status
);

   // R12: an open switch is always isolated
   p_iso_guard_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_on |-> iso_on);

   // R3: isolation rises mid power-down with the switch still closed
   p_iso_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iso_on) |-> (seq_busy && sw_on));

   // R4: switch opening ends the power-down
   p_sw_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_on) |-> (iso_on && !seq_busy));

   // R5: switch closes mid power-up while still isolated
   p_sw_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_on) |-> (iso_on && seq_busy));

   // R6: isolation release ends the power-up
   p_iso_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso_on) |-> (sw_on && !seq_busy));

   // R7: vetoed request keeps the domain on and idle
   p_veto_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_busy && sw_on && down_req && !pwr_en) |=> (!seq_busy && sw_on && !iso_on && !status));

   // R8: power removal records status
   p_status_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_on) |-> status);

   // R9: power-up request while on is ignored
   p_up_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_busy && sw_on && up_req && !down_req) |=> (!seq_busy && sw_on && !iso_on));

   // R9: power-down request while off is ignored
   p_down_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_busy && !sw_on && down_req && !up_req) |=> (!seq_busy && !sw_on && iso_on));

endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .down_req(down_req),
   .up_req  (up_req),
   .sw_on   (sw_on),
   .iso_on  (iso_on),
   .seq_busy(seq_busy),
   .pwr_en  (pwr_en_w),
   .status  (status_w)
);

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_sel, reg_wr;
   logic [3:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        down_req, up_req;
   logic        sw_on, iso_on, seq_busy;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwr_seq_ctrl i_pwr_seq_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_sel  (reg_sel),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .down_req (down_req),
      .up_req   (up_req),
      .sw_on    (sw_on),
      .iso_on   (iso_on),
      .seq_busy (seq_busy)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
      #2;
      d = reg_rdata;
      reg_sel = 1'b0;
   endtask

   // one full sequence; k counts falling edges after the request was sampled
   task automatic run_seq(input bit down, input int d1, input int d2, input bit noise);
      int k = 0, k_first = 0, k_end = 0;
      bit order_ok = 1'b1;
      logic [31:0] v;
      if (down) begin
         wr(4'h8, 32'((d2 << 8) | d1));
         wr(4'h0, 32'd1);
      end else begin
         wr(4'h4, 32'((d2 << 8) | d1));
      end
      @(negedge clk);
      if (down) down_req = 1'b1; else up_req = 1'b1;
      while (k < 300) begin
         @(negedge clk);
         down_req = 1'b0; up_req = 1'b0;
         k++;
         if (noise && k == 2) begin
            down_req = 1'b1; up_req = 1'b1;
         end
         if (!sw_on && !iso_on) order_ok = 1'b0;
         if (k_first == 0 && (down ? iso_on : sw_on)) k_first = k;
         if (!seq_busy) begin
            k_end = k;
            break;
         end
      end
      chk(order_ok, "R12 switch open without isolation", 0, 1);
      chk(k_end == d1 + d2 + 3, "R11 busy span", k_end, d1 + d2 + 3);
      if (down) begin
         chk(k_first == d1 + 2, "R3 isolation delay", k_first, d1 + 2);
         chk(k_end - k_first == d2 + 1, "R4 switch-off delay", k_end - k_first, d2 + 1);
         chk(!sw_on && iso_on, "R4 final off state", {sw_on, iso_on}, 2'b01);
         rd(4'hC, v);
         chk(v == 32'd1, "R8 status after power-off", v, 1);
      end else begin
         chk(k_first == d1 + 2, "R5 switch-on delay", k_first, d1 + 2);
         chk(k_end - k_first == d2 + 1, "R6 isolation release delay", k_end - k_first, d2 + 1);
         chk(sw_on && !iso_on, "R6 final on state", {sw_on, iso_on}, 2'b10);
         rd(4'hC, v);
         chk(v == 32'd1, "R8 status kept through power-up", v, 1);
      end
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int vals[5] = '{0, 1, 2, 7, 63};
      logic [31:0] v;
      int k;
      rst_n = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      down_req = 1'b0; up_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk(sw_on && !iso_on && !seq_busy, "R1 reset outputs", {sw_on, iso_on, seq_busy}, 3'b100);
      for (int a = 0; a < 4; a++) begin
         rd(4'(a * 4), v);
         chk(v == 32'd0, "R1 register reset value", v, 0);
      end

      // R2 field layout and unused bits
      wr(4'h0, 32'hFFFF_FFFF);
      wr(4'h4, 32'hFFFF_FFFF);
      wr(4'h8, 32'hFFFF_FFFF);
      wr(4'hC, 32'hFFFF_FFFF);
      rd(4'h0, v); chk(v == 32'h1, "R2 control readback", v, 32'h1);
      rd(4'h4, v); chk(v == 32'h3F3F, "R2 power-up timing readback", v, 32'h3F3F);
      rd(4'h8, v); chk(v == 32'h3F3F, "R2 power-down timing readback", v, 32'h3F3F);
      rd(4'hC, v); chk(v == 32'h0, "R2 status not settable by write", v, 0);
      wr(4'h4, 32'h0000_1205);
      rd(4'h4, v); chk(v == 32'h1205, "R2 distinct field values", v, 32'h1205);

      // R9 power-up request while on
      @(negedge clk); up_req = 1'b1;
      @(negedge clk); up_req = 1'b0;
      idle_cycles(3);
      chk(sw_on && !iso_on && !seq_busy, "R9 up request while on ignored",
          {sw_on, iso_on, seq_busy}, 3'b100);

      // delay sweep, both directions, noise on alternate runs
      for (int a = 0; a < 5; a++) begin
         for (int b = 0; b < 5; b++) begin
            run_seq(1'b1, vals[a], vals[b], 1'((a + b) % 2));
            if (a == 1 && b == 1) begin
               // R9 power-down request while off
               @(negedge clk); down_req = 1'b1;
               @(negedge clk); down_req = 1'b0;
               idle_cycles(3);
               chk(!sw_on && iso_on && !seq_busy, "R9 down request while off ignored",
                   {sw_on, iso_on, seq_busy}, 3'b010);
            end
            run_seq(1'b0, vals[b], vals[a], 1'((a + b + 1) % 2));
         end
      end

      // R8 status cleared by write
      wr(4'hC, 32'd0);
      rd(4'hC, v); chk(v == 32'd0, "R8 status write clears", v, 0);

      // R7 veto: set status first, then request with enable 0
      run_seq(1'b1, 1, 1, 1'b0);
      run_seq(1'b0, 1, 1, 1'b0);
      wr(4'h0, 32'd0);
      @(negedge clk); down_req = 1'b1;
      @(negedge clk); down_req = 1'b0;
      chk(sw_on && !iso_on && !seq_busy, "R7 veto keeps domain on",
          {sw_on, iso_on, seq_busy}, 3'b100);
      idle_cycles(4);
      chk(sw_on && !iso_on && !seq_busy, "R7 veto still on later",
          {sw_on, iso_on, seq_busy}, 3'b100);
      rd(4'hC, v); chk(v == 32'd0, "R7 veto clears status", v, 0);

      // R10 enable cleared mid-sequence does not stop power-off
      wr(4'h8, 32'h0000_0A0A);
      wr(4'h0, 32'd1);
      @(negedge clk); down_req = 1'b1;
      @(negedge clk); down_req = 1'b0;
      wr(4'h0, 32'd0);
      k = 0;
      while (seq_busy && k < 100) begin
         @(negedge clk);
         k++;
      end
      chk(!sw_on && iso_on, "R10 power-off completes after enable cleared",
          {sw_on, iso_on}, 2'b01);
      rd(4'hC, v); chk(v == 32'd1, "R10 status after sampled enable", v, 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule